// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Unit

This block turns up to eight chosen input pins into eight interrupt request lines. Each channel has a select register that chooses one pin out of the pin bus. The chosen pin is passed through a two-flop synchronizer. A third flop holds the previous sample, and comparing the two detects rising and falling edges. Each channel works either on edges, where detected edges are held in rising and falling flag bits until software clears them, or on levels, where the request follows the pin for as long as the active level lasts.

Software sees a small byte-wide register space. It holds one select byte per channel and a mode byte. Two enable bytes serve both modes: in level mode one acts as the level enable and the other picks the polarity. There are also two flag bytes, a status byte and a wake-enable byte. In every byte, bit n belongs to channel n. A wake output combines the requests of the channels that have wake enabled, so that a power controller outside the block can leave a deep low-power state.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset every register reads zero, so all channels are in edge mode with all enables off, and `irq_o` and `wake_o` are low.
- R2: The byte at address n (n = 0..7) selects the pin for channel n. Its low bits index `pins_i`, and it reads back as written. A pin that no channel selects sets no flag.
- R3: A rising edge on a channel's selected pin sets bit n of the rising flag byte (address 11) on the third clock edge after the pin changes, and not before.
- R4: A falling edge on a selected pin sets bit n of the falling flag byte (address 12) on the same schedule as R3.
- R5: Writing a 1 to a bit of address 11 or 12 clears that flag. Writing a 0 leaves the flag unchanged.
- R6: In edge mode (bit n of address 8 is 0), `irq_o[n]` and status bit n (address 13) are high when the rising flag and the rising enable (address 9) are both set, or when the falling flag and the falling enable (address 10) are both set.
- R7: In edge mode, writing a 1 to status bit n clears both edge flags of channel n and so drops its request.
- R8: In level mode (bit n of address 8 is 1), the request is high when the level enable (address 9 bit n) is set and the synchronized pin equals the polarity bit (address 10 bit n, 1 = active high). The request appears two clock edges after the pin change.
- R9: In level mode, a write of 1 to status bit n has no effect on the request while the active level persists.
- R10: If an edge is detected on a channel in the same cycle as a write that clears its flag, the flag stays set.
- R11: `wake_o` is high exactly when some channel has a request and its wake-enable bit (address 14) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Pin bus to choose channel sources from |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for reads and writes |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | NUM_CH | One interrupt request per channel |
| wake_o | output | 1 | Combined wake request |

## Verification
The assertions take for granted that the pins may change at any time but that register writes are single-cycle strobes with stable address and data. The flag properties also assume that reset is held long enough to clear the synchronizer flops before the first write. The stimulus changes pins and write strobes only on falling clock edges, holds each pin level for at least three cycles so that every edge passes the synchronizer, and keeps every write to a one-cycle strobe. The same-cycle case for R10 is timed on purpose so that the clear write lands in the one cycle where the edge is detected.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_MODE   = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_EN_R   = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_EN_F   = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_FLAG_R = 4'd11;
  localparam logic [ADDR_W-1:0] ADR_FLAG_F = 4'd12;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 4'd13;
  localparam logic [ADDR_W-1:0] ADR_WAKE   = 4'd14;

  // edge-mode request from latched flags and their enables
  function automatic logic f_edge_req(input logic rflag, input logic fflag,
                                      input logic ren, input logic fen);
    return (rflag & ren) | (fflag & fen);
  endfunction

  // level-mode request: enabled and pin matches polarity
  function automatic logic f_level_req(input logic lvl, input logic en,
                                       input logic act_high);
    return en & (lvl == act_high);
  endfunction

  // flag update: a new edge overrides a clear in the same cycle
  function automatic logic f_next_flag(input logic cur, input logic clr,
                                       input logic det);
    return (cur & ~clr) | det;
  endfunction
endpackage

// File: rtl/pin_irq_front.sv
module pin_irq_front #(
  parameter int NUM_PINS = 16,
  localparam int SEL_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                lvl_o,
  output logic                rise_o,
  output logic                fall_o
);
  logic pick;
  logic sync1_q, sync2_q, prev_q;

  assign pick = pins_i[sel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pick;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign lvl_o  = sync2_q;
  assign rise_o = sync2_q & ~prev_q;
  assign fall_o = ~sync2_q & prev_q;
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan
  import pin_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_det_i,
  input  logic fall_det_i,
  input  logic clr_r_i,
  input  logic clr_f_i,
  input  logic level_mode_i,
  input  logic en_r_i,
  input  logic en_f_i,
  input  logic lvl_i,
  output logic rflag_o,
  output logic fflag_o,
  output logic req_o
);
  logic rflag_q, fflag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rflag_q <= 1'b0;
      fflag_q <= 1'b0;
    end else begin
      rflag_q <= f_next_flag(rflag_q, clr_r_i, rise_det_i);
      fflag_q <= f_next_flag(fflag_q, clr_f_i, fall_det_i);
    end
  end

  assign rflag_o = rflag_q;
  assign fflag_o = fflag_q;
  assign req_o   = level_mode_i ? f_level_req(lvl_i, en_r_i, en_f_i)
                                : f_edge_req(rflag_q, fflag_q, en_r_i, en_f_i);
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 4,
  localparam int CH_IW = $clog2(NUM_CH)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [REG_W-1:0]                 wdata_i,
  output logic [REG_W-1:0]                 rdata_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]     sel_o,
  output logic [NUM_CH-1:0]                mode_o,
  output logic [NUM_CH-1:0]                en_r_o,
  output logic [NUM_CH-1:0]                en_f_o,
  output logic [NUM_CH-1:0]                wake_en_o,
  output logic [NUM_CH-1:0]                clr_r_o,
  output logic [NUM_CH-1:0]                clr_f_o,
  input  logic [NUM_CH-1:0]                rflag_i,
  input  logic [NUM_CH-1:0]                fflag_i,
  input  logic [NUM_CH-1:0]                req_i
);
  logic [NUM_CH-1:0][REG_W-1:0] sel_q;
  logic [NUM_CH-1:0] mode_q, en_r_q, en_f_q, wake_q;
  logic [NUM_CH-1:0] wr_bits, stat_clr;
  logic              is_sel;

  assign is_sel   = (addr_i < ADDR_W'(NUM_CH));
  assign wr_bits  = wdata_i[NUM_CH-1:0];
  assign stat_clr = (wr_i && addr_i == ADR_STAT) ? (wr_bits & ~mode_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= '0;
      en_r_q <= '0;
      en_f_q <= '0;
      wake_q <= '0;
    end else if (wr_i) begin
      if (is_sel) sel_q[addr_i[CH_IW-1:0]] <= wdata_i;
      case (addr_i)
        ADR_MODE: mode_q <= wr_bits;
        ADR_EN_R: en_r_q <= wr_bits;
        ADR_EN_F: en_f_q <= wr_bits;
        ADR_WAKE: wake_q <= wr_bits;
        default: ;
      endcase
    end
  end

  assign clr_r_o = ((wr_i && addr_i == ADR_FLAG_R) ? wr_bits : '0) | stat_clr;
  assign clr_f_o = ((wr_i && addr_i == ADR_FLAG_F) ? wr_bits : '0) | stat_clr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign sel_o[g] = sel_q[g][SEL_W-1:0];
  end

  assign mode_o    = mode_q;
  assign en_r_o    = en_r_q;
  assign en_f_o    = en_f_q;
  assign wake_en_o = wake_q;

  always_comb begin
    rdata_o = '0;
    if (is_sel) begin
      rdata_o = sel_q[addr_i[CH_IW-1:0]];
    end else begin
      case (addr_i)
        ADR_MODE:   rdata_o = REG_W'(mode_q);
        ADR_EN_R:   rdata_o = REG_W'(en_r_q);
        ADR_EN_F:   rdata_o = REG_W'(en_f_q);
        ADR_FLAG_R: rdata_o = REG_W'(rflag_i);
        ADR_FLAG_F: rdata_o = REG_W'(fflag_i);
        ADR_STAT:   rdata_o = REG_W'(req_i);
        ADR_WAKE:   rdata_o = REG_W'(wake_q);
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_PINS = 16,
  localparam int SEL_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic [NUM_CH-1:0]   irq_o,
  output logic                wake_o
);
  logic [NUM_CH-1:0][SEL_W-1:0] sel;
  logic [NUM_CH-1:0] mode, en_r, en_f, wake_en;
  logic [NUM_CH-1:0] clr_r, clr_f;
  logic [NUM_CH-1:0] lvl, rise_det, fall_det;
  logic [NUM_CH-1:0] rise_flag, fall_flag, req;

  pin_irq_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .sel_o(sel), .mode_o(mode), .en_r_o(en_r), .en_f_o(en_f),
    .wake_en_o(wake_en), .clr_r_o(clr_r), .clr_f_o(clr_f),
    .rflag_i(rise_flag), .fflag_i(fall_flag), .req_i(req)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pin_irq_front #(.NUM_PINS(NUM_PINS)) u_front (
      .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .sel_i(sel[g]),
      .lvl_o(lvl[g]), .rise_o(rise_det[g]), .fall_o(fall_det[g])
    );
    pin_irq_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .rise_det_i(rise_det[g]), .fall_det_i(fall_det[g]),
      .clr_r_i(clr_r[g]), .clr_f_i(clr_f[g]),
      .level_mode_i(mode[g]), .en_r_i(en_r[g]), .en_f_i(en_f[g]),
      .lvl_i(lvl[g]),
      .rflag_o(rise_flag[g]), .fflag_o(fall_flag[g]), .req_o(req[g])
    );
  end

  assign irq_o  = req;
  assign wake_o = |(req & wake_en);
endmodule

// File: rtl/pin_irq_unit_chk.sv
module pin_irq_unit_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] mode,
  input logic [NUM_CH-1:0] irq,
  input logic              wake,
  input logic [NUM_CH-1:0] rise_det,
  input logic [NUM_CH-1:0] clr_r,
  input logic [NUM_CH-1:0] rise_flag,
  input logic [NUM_CH-1:0] fall_flag
);
  AST_RFLAG_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_flag & ~$past(rise_flag) & ~$past(rise_det)) == '0); // R3
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_det) |=> ((rise_flag & $past(rise_det)) == $past(rise_det))); // R10
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_r & ~rise_det)) |=> ((rise_flag & $past(clr_r & ~rise_det)) == '0)); // R5
  AST_EDGE_REQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~mode & ~(rise_flag | fall_flag)) == '0); // R6
  AST_WAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (|irq)); // R11
endmodule

bind pin_irq_unit pin_irq_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .irq(irq_o), .wake(wake_o),
  .rise_det(rise_det), .clr_r(clr_r), .rise_flag(rise_flag),
  .fall_flag(fall_flag)
);

// File: tb/test_pin_irq_unit.sv
module test_pin_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int NP  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          wr = 1'b0;
  logic [3:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [NCH-1:0] irq;
  logic          wake;
  int            total = 0;
  int            bad = 0;
  logic [7:0]    v;

  pin_irq_unit #(.NUM_CH(NCH), .NUM_PINS(NP)) i_pin_irq_unit (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .wake_o(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic clear_flags();
    wreg(4'd11, 8'hFF); wreg(4'd12, 8'hFF);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 15; a++) begin
      rreg(4'(a), v); chk("R1 reg", v, 8'h00);
    end
    chk("R1 irq", irq, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);
  endtask

  task automatic t_select();
    wreg(4'd2, 8'd5);
    rreg(4'd2, v); chk("R2 readback", v, 8'd5);
    clear_flags();
    pins[4] = 1'b1; tick(4);
    rreg(4'd11, v); chk("R2 unselected pin", v, 8'h00);
    pins[5] = 1'b1; tick(4);
    rreg(4'd11, v); chk("R2 selected pin", v, 8'h04);
  endtask

  task automatic t_rise_fall();
    clear_flags();
    pins[0] = 1'b1; tick(2);
    rreg(4'd11, v); chk("R3 not yet", v, 8'h00);
    tick(1);
    rreg(4'd11, v); chk("R3 set", v, 8'hFB);
    rreg(4'd12, v); chk("R3 no fall", v, 8'h00);
    pins[0] = 1'b0; tick(3);
    rreg(4'd12, v); chk("R4 set", v, 8'hFB);
  endtask

  task automatic t_clear();
    wreg(4'd11, 8'h01);
    rreg(4'd11, v); chk("R5 clear one", v, 8'hFA);
    wreg(4'd12, 8'h00);
    rreg(4'd12, v); chk("R5 zero write", v, 8'hFB);
  endtask

  task automatic t_edge_req();
    clear_flags();
    wreg(4'd9, 8'h01);
    chk("R6 idle", irq, 8'h00);
    pins[0] = 1'b1; tick(3);
    chk("R6 rise irq", irq & 8'h01, 8'h01);
    rreg(4'd13, v); chk("R6 status", v, 8'h01);
    wreg(4'd9, 8'h00); wreg(4'd10, 8'h01);
    chk("R6 fall only", irq, 8'h00);
    pins[0] = 1'b0; tick(3);
    chk("R6 fall irq", irq, 8'h01);
    wreg(4'd13, 8'h01);
    chk("R7 irq cleared", irq, 8'h00);
    rreg(4'd11, v); chk("R7 rise flag", v & 8'h01, 8'h00);
    rreg(4'd12, v); chk("R7 fall flag", v & 8'h01, 8'h00);
    wreg(4'd10, 8'h00);
  endtask

  task automatic t_coincide();
    clear_flags();
    pins[0] = 1'b1; tick(4);
    pins[0] = 1'b0; tick(4);
    pins[0] = 1'b1; tick(2);
    wreg(4'd11, 8'h01);
    rreg(4'd11, v); chk("R10 edge wins", v & 8'h01, 8'h01);
    tick(2);
    wreg(4'd11, 8'h01);
    rreg(4'd11, v); chk("R10 later clear", v & 8'h01, 8'h00);
  endtask

  task automatic t_level();
    wreg(4'd1, 8'd3);
    wreg(4'd8, 8'h02); wreg(4'd9, 8'h02); wreg(4'd10, 8'h02);
    chk("R8 low level", irq & 8'h02, 8'h00);
    pins[3] = 1'b1; tick(1);
    chk("R8 one edge", irq & 8'h02, 8'h00);
    tick(1);
    chk("R8 high active", irq & 8'h02, 8'h02);
    wreg(4'd13, 8'h02);
    chk("R9 sticky", irq & 8'h02, 8'h02);
    wreg(4'd10, 8'h00);
    chk("R8 polarity low", irq & 8'h02, 8'h00);
    pins[3] = 1'b0; tick(2);
    chk("R8 low active", irq & 8'h02, 8'h02);
  endtask

  task automatic t_wake();
    wreg(4'd14, 8'h02);
    chk("R11 wake on", {7'd0, wake}, 8'h01);
    wreg(4'd14, 8'h01);
    chk("R11 wake off", {7'd0, wake}, 8'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_select();
    t_rise_fall();
    t_clear();
    t_edge_req();
    t_coincide();
    t_level();
    t_wake();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule